// File: doc/BRIEF.md
# Store Write Buffer with Byte-Wise Load Bypass

This block sits between a processor's store path and its data cache. Stores are accepted into a small in-order queue and the processor moves on immediately, so it does not wait on the cache. The queue then hands entries to the cache in the background, one per cycle, whenever the cache signals it can take one. Each entry holds a word-aligned address, one word of data and a valid flag for each byte.

Loads probe the buffer while the cache array is being read. The block takes the cache's read word and replaces every byte that the buffer holds for that word address. Where several buffered entries hold the same byte, the youngest one wins. A separate flag reports whether the buffer alone supplies every byte the load asks for. Miss handling can use this flag to complete such a load without a stall.

Consecutive stores to the same word are merged into the youngest waiting entry. A store is never merged into an older entry when a store to a different word lies between them, so the drain order always follows program order.

Top module: `swb_top`

## Requirements
- R1: When `st_valid_i` and `st_ready_o` are both high at a clock edge, the store is taken. If the buffer was empty, the store is offered on the drain port in the very next cycle.
- R2: `st_ready_o` is low exactly when all DEPTH entries (default 4) are occupied. A store offered while it is low changes nothing.
- R3: `dr_valid_o` is high whenever the buffer holds at least one entry. The drain port always shows the oldest entry and holds it until `dr_ready_i` is high at a clock edge. At most one entry leaves per cycle, and entries leave in program order.
- R4: A taken store whose word address equals the youngest entry's address is merged into that entry. Its enabled bytes overwrite the older ones and the byte-valid flags are ORed together. There is one exception: when that entry is the only one and is drained in the same cycle, the store goes into a new entry instead.
- R5: A store to word A, then a store to word B, then another store to A gives three separate entries, drained as A, B, A.
- R6: `ld_data_o` equals `ld_cache_data_i` with byte b (bits 8b+7..8b) replaced wherever a buffered entry for `ld_addr_i` has byte-valid bit b set. The byte-valid and byte-enable bit b always refers to bits 8b+7..8b.
- R7: When several buffered entries match the load address, each byte comes from the youngest matching entry that has that byte valid.
- R8: `ld_covered_o` is high only when `ld_be_i` is nonzero and every byte enabled in `ld_be_i` is valid in some matching entry. The probe reflects the buffer contents before the current cycle's store.
- R9: After reset the buffer is empty: `st_ready_o` is high, `dr_valid_o` is low, `ld_covered_o` is low and `ld_data_o` equals `ld_cache_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request |
| st_ready_o | output | 1 | Buffer can take a store |
| st_addr_i | input | AW | Store word address |
| st_data_i | input | 8*NB | Store data |
| st_be_i | input | NB | Store byte enables |
| ld_addr_i | input | AW | Load probe word address |
| ld_be_i | input | NB | Bytes requested by the load |
| ld_cache_data_i | input | 8*NB | Word read from the cache |
| ld_data_o | output | 8*NB | Cache word merged with buffered bytes |
| ld_covered_o | output | 1 | Buffer supplies all requested bytes |
| dr_valid_o | output | 1 | Oldest entry offered to the cache |
| dr_ready_i | input | 1 | Cache takes the offered entry |
| dr_addr_o | output | AW | Drained word address |
| dr_data_o | output | 8*NB | Drained data |
| dr_be_o | output | NB | Drained byte-valid flags |

## Verification
A corrupt head pointer or count shows up on the drain port in the same cycle. It appears as a wrong address, an entry that is missing, or an entry that repeats against the program-order sequence. A coalescing error stays hidden in storage until the next load probe to that word, or until that entry reaches the drain port. The bench therefore probes random addresses every cycle from a small address pool. This brings such a fault to `ld_data_o` or `ld_covered_o` within a few cycles.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int unsigned SWB_AW    = 10;
  localparam int unsigned SWB_NB    = 4;
  localparam int unsigned SWB_DEPTH = 4;

  // (a + b) mod n for a < n, b < n
  function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned n);
    int unsigned s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/swb_store.sv
module swb_store import swb_pkg::*; #(
  parameter int unsigned AW    = SWB_AW,
  parameter int unsigned NB    = SWB_NB,
  parameter int unsigned DEPTH = SWB_DEPTH,
  localparam int unsigned DW   = 8 * NB,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          st_valid_i,
  output logic                          st_ready_o,
  input  logic [AW-1:0]                 st_addr_i,
  input  logic [DW-1:0]                 st_data_i,
  input  logic [NB-1:0]                 st_be_i,
  output logic                          dr_valid_o,
  input  logic                          dr_ready_i,
  output logic [AW-1:0]                 dr_addr_o,
  output logic [DW-1:0]                 dr_data_o,
  output logic [NB-1:0]                 dr_be_o,
  output logic [DEPTH-1:0][AW-1:0]      ent_addr_o,
  output logic [DEPTH-1:0][DW-1:0]      ent_data_o,
  output logic [DEPTH-1:0][NB-1:0]      ent_be_o,
  output logic [PW-1:0]                 head_o,
  output logic [CW-1:0]                 cnt_o
);
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [DEPTH-1:0][NB-1:0] be_q;
  logic [PW-1:0]            head_q, tail_idx, yng_idx, head_nxt;
  logic [CW-1:0]            cnt_q;
  logic                     drain_fire, st_fire, merge, alloc;

  assign tail_idx = PW'(wrap_add(int'(head_q), int'(cnt_q) % DEPTH, DEPTH));
  assign yng_idx  = PW'(wrap_add(int'(head_q), (cnt_q == '0) ? 0 : int'(cnt_q) - 1, DEPTH));
  assign head_nxt = PW'(wrap_add(int'(head_q), 1, DEPTH));

  assign st_ready_o = (cnt_q != CW'(DEPTH));
  assign dr_valid_o = (cnt_q != '0);
  assign drain_fire = dr_valid_o && dr_ready_i;
  assign st_fire    = st_valid_i && st_ready_o;
  // never merge into an entry leaving this cycle
  assign merge      = st_fire && (cnt_q != '0) && (addr_q[yng_idx] == st_addr_i)
                      && !((cnt_q == CW'(1)) && drain_fire);
  assign alloc      = st_fire && !merge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (merge) begin
        for (int b = 0; b < int'(NB); b++) begin
          if (st_be_i[b]) data_q[yng_idx][8*b +: 8] <= st_data_i[8*b +: 8];
        end
        be_q[yng_idx] <= be_q[yng_idx] | st_be_i;
      end
      if (alloc) begin
        addr_q[tail_idx] <= st_addr_i;
        data_q[tail_idx] <= st_data_i;
        be_q[tail_idx]   <= st_be_i;
      end
      if (drain_fire) head_q <= head_nxt;
      cnt_q <= cnt_q + CW'(alloc) - CW'(drain_fire);
    end
  end

  assign dr_addr_o  = addr_q[head_q];
  assign dr_data_o  = data_q[head_q];
  assign dr_be_o    = be_q[head_q];
  assign ent_addr_o = addr_q;
  assign ent_data_o = data_q;
  assign ent_be_o   = be_q;
  assign head_o     = head_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/swb_fwd.sv
module swb_fwd import swb_pkg::*; #(
  parameter int unsigned AW    = SWB_AW,
  parameter int unsigned NB    = SWB_NB,
  parameter int unsigned DEPTH = SWB_DEPTH,
  localparam int unsigned DW   = 8 * NB,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr_i,
  input  logic [DEPTH-1:0][DW-1:0] ent_data_i,
  input  logic [DEPTH-1:0][NB-1:0] ent_be_i,
  input  logic [PW-1:0]            head_i,
  input  logic [CW-1:0]            cnt_i,
  input  logic [AW-1:0]            ld_addr_i,
  input  logic [NB-1:0]            ld_be_i,
  input  logic [DW-1:0]            ld_cache_data_i,
  output logic [DW-1:0]            ld_data_o,
  output logic                     ld_covered_o
);
  logic [NB-1:0] byte_hit;

  // per byte: scan oldest to youngest so younger entries win
  for (genvar gb = 0; gb < int'(NB); gb++) begin : g_byte
    always_comb begin
      ld_data_o[8*gb +: 8] = ld_cache_data_i[8*gb +: 8];
      byte_hit[gb]         = 1'b0;
      for (int k = 0; k < int'(DEPTH); k++) begin
        if (CW'(k) < cnt_i) begin
          if (ent_addr_i[PW'(wrap_add(int'(head_i), k, DEPTH))] == ld_addr_i &&
              ent_be_i[PW'(wrap_add(int'(head_i), k, DEPTH))][gb]) begin
            ld_data_o[8*gb +: 8] = ent_data_i[PW'(wrap_add(int'(head_i), k, DEPTH))][8*gb +: 8];
            byte_hit[gb]         = 1'b1;
          end
        end
      end
    end
  end

  assign ld_covered_o = (ld_be_i != '0) && ((byte_hit & ld_be_i) == ld_be_i);
endmodule

// File: rtl/swb_top.sv
module swb_top import swb_pkg::*; #(
  parameter int unsigned AW    = SWB_AW,
  parameter int unsigned NB    = SWB_NB,
  parameter int unsigned DEPTH = SWB_DEPTH,
  localparam int unsigned DW   = 8 * NB,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  output logic          st_ready_o,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [NB-1:0] st_be_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [NB-1:0] ld_be_i,
  input  logic [DW-1:0] ld_cache_data_i,
  output logic [DW-1:0] ld_data_o,
  output logic          ld_covered_o,
  output logic          dr_valid_o,
  input  logic          dr_ready_i,
  output logic [AW-1:0] dr_addr_o,
  output logic [DW-1:0] dr_data_o,
  output logic [NB-1:0] dr_be_o
);
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic [DEPTH-1:0][NB-1:0] ent_be;
  logic [PW-1:0]            head;
  logic [CW-1:0]            cnt;

  swb_store #(.AW(AW), .NB(NB), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .st_valid_i, .st_ready_o, .st_addr_i, .st_data_i, .st_be_i,
    .dr_valid_o, .dr_ready_i, .dr_addr_o, .dr_data_o, .dr_be_o,
    .ent_addr_o(ent_addr), .ent_data_o(ent_data), .ent_be_o(ent_be),
    .head_o(head), .cnt_o(cnt)
  );

  swb_fwd #(.AW(AW), .NB(NB), .DEPTH(DEPTH)) u_fwd (
    .ent_addr_i(ent_addr), .ent_data_i(ent_data), .ent_be_i(ent_be),
    .head_i(head), .cnt_i(cnt),
    .ld_addr_i, .ld_be_i, .ld_cache_data_i, .ld_data_o, .ld_covered_o
  );
endmodule

// File: rtl/swb_chk.sv
module swb_chk #(
  parameter int unsigned AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          st_valid_i,
  input logic          st_ready_o,
  input logic          dr_valid_o,
  input logic          dr_ready_i,
  input logic [AW-1:0] dr_addr_o,
  input logic          ld_covered_o
);
  AST_STORE_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && st_ready_o && !dr_valid_o |=> dr_valid_o); // R1
  AST_FULL_HAS_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_ready_o |-> dr_valid_o); // R2
  AST_READY_AFTER_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_valid_o && dr_ready_i |=> st_ready_o); // R2
  AST_DRAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_valid_o && !dr_ready_i |=> dr_valid_o && $stable(dr_addr_o)); // R3
  AST_EMPTY_NO_COVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dr_valid_o |-> !ld_covered_o); // R8
endmodule

bind swb_top swb_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .st_valid_i(st_valid_i), .st_ready_o(st_ready_o),
  .dr_valid_o(dr_valid_o), .dr_ready_i(dr_ready_i), .dr_addr_o(dr_addr_o),
  .ld_covered_o(ld_covered_o)
);

// File: tb/sim_swb_top.sv
module sim_swb_top;
  localparam int CLK_P = 10;
  localparam int AW = 10, NB = 4, DW = 32, DEPTH = 4;

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; logic [NB-1:0] be; } ent_t;
  ent_t mq[$];

  logic clk = 0, rst_n = 0;
  logic st_v = 0, dr_rdy = 0;
  logic [AW-1:0] st_a = '0, ld_a = '0;
  logic [DW-1:0] st_d = '0, cache_d = '0;
  logic [NB-1:0] st_b = '0, ld_b = '0;
  logic st_rdy, dr_v, ld_cov;
  logic [AW-1:0] dr_a;
  logic [DW-1:0] dr_d, ld_d;
  logic [NB-1:0] dr_b;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  swb_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_v), .st_ready_o(st_rdy), .st_addr_i(st_a), .st_data_i(st_d), .st_be_i(st_b),
    .ld_addr_i(ld_a), .ld_be_i(ld_b), .ld_cache_data_i(cache_d), .ld_data_o(ld_d), .ld_covered_o(ld_cov),
    .dr_valid_o(dr_v), .dr_ready_i(dr_rdy), .dr_addr_o(dr_a), .dr_data_o(dr_d), .dr_be_o(dr_b)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_ld_data();
    logic [DW-1:0] r = cache_d;
    foreach (mq[i]) if (mq[i].a == ld_a)
      for (int b = 0; b < NB; b++) if (mq[i].be[b]) r[8*b +: 8] = mq[i].d[8*b +: 8];
    return r;
  endfunction

  function automatic logic exp_cov();
    logic [NB-1:0] h = '0;
    foreach (mq[i]) if (mq[i].a == ld_a) h |= mq[i].be;
    return (ld_b != '0) && ((h & ld_b) == ld_b);
  endfunction

  // compare against model, take one clock, update model
  task automatic step();
    bit dfire, sfire, mg;
    ent_t e;
    #1;
    chk("R2 st_ready", 64'(st_rdy), 64'(mq.size() < DEPTH));
    chk("R3 dr_valid", 64'(dr_v), 64'(mq.size() != 0));
    if (mq.size() != 0) begin
      chk("R3 dr_addr", 64'(dr_a), 64'(mq[0].a));
      chk("R3 dr_be", 64'(dr_b), 64'(mq[0].be));
      chk("R3 dr_data", 64'(dr_d), 64'(mq[0].d));
    end
    chk("R6 ld_data", 64'(ld_d), 64'(exp_ld_data()));
    chk("R8 ld_covered", 64'(ld_cov), 64'(exp_cov()));
    @(posedge clk);
    dfire = (mq.size() != 0) && dr_rdy;
    sfire = st_v && (mq.size() < DEPTH);
    mg = sfire && (mq.size() != 0) && (mq[$].a == st_a) && !(mq.size() == 1 && dfire);
    if (mg) begin
      e = mq[$];
      for (int b = 0; b < NB; b++) if (st_b[b]) e.d[8*b +: 8] = st_d[8*b +: 8];
      e.be |= st_b;
      mq[$] = e;
    end
    if (dfire) void'(mq.pop_front());
    if (sfire && !mg) mq.push_back('{st_a, st_d, st_b});
    @(negedge clk);
  endtask

  task automatic store(logic [AW-1:0] a, logic [DW-1:0] d, logic [NB-1:0] b);
    st_v = 1; st_a = a; st_d = d; st_b = b;
    step();
    st_v = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    cache_d = 32'hCCCC_CCCC; ld_a = 5; ld_b = 4'hF;
    #1;
    chk("R9 st_ready", 64'(st_rdy), 1);
    chk("R9 dr_valid", 64'(dr_v), 0);
    chk("R9 ld_covered", 64'(ld_cov), 0);
    chk("R9 ld_data", 64'(ld_d), 64'(32'hCCCC_CCCC));
    rst_n = 1;
    @(negedge clk);

    // R1 / R4: merge two stores to word 5
    dr_rdy = 0;
    store(5, 32'h0000_1122, 4'b0011);
    #1 chk("R1 visible", 64'(dr_v), 1);
    store(5, 32'h00AA_BB00, 4'b0110);
    #1;
    chk("R4 merged be", 64'(dr_b), 64'(4'b0111));
    chk("R4 merged data", 64'(dr_d[23:0]), 64'(24'hAABB22));
    ld_a = 5; ld_b = 4'b0111; #1;
    chk("R8 covered full", 64'(ld_cov), 1);
    ld_b = 4'b1111; #1;
    chk("R8 covered partial", 64'(ld_cov), 0);
    chk("R6 merge", 64'(ld_d), 64'(32'hCCAA_BB22));

    // R5 / R7
    store(6, 32'h0000_0033, 4'b0001);
    store(5, 32'h4400_0000, 4'b1000);
    store(5, 32'h0000_0055, 4'b0001);
    ld_a = 5; ld_b = 4'hF; #1;
    chk("R7 youngest wins", 64'(ld_d), 64'(32'h44AA_BB55));
    chk("R8 covered union", 64'(ld_cov), 1);
    dr_rdy = 1;
    #1 chk("R5 order 0", 64'(dr_a), 5);
    step();
    #1 chk("R5 order 1", 64'(dr_a), 6);
    step();
    #1 chk("R5 order 2", 64'(dr_a), 5);
    chk("R5 order 2 be", 64'(dr_b), 64'(4'b1001));
    step();
    #1 chk("R3 empty", 64'(dr_v), 0);

    // R2: fill, then a store while full has no effect
    dr_rdy = 0;
    for (int i = 0; i < DEPTH; i++) store(AW'(16 + i), 32'(i), 4'hF);
    #1 chk("R2 full", 64'(st_rdy), 0);
    store(99, 32'hDEAD_BEEF, 4'hF);
    dr_rdy = 1;
    for (int i = 0; i < DEPTH; i++) begin
      #1 chk("R2 drained entry", 64'(dr_a), 64'(16 + i));
      step();
    end
    #1 chk("R2 ignored store", 64'(dr_v), 0);

    // R4 corner: single entry drained while same-word store arrives
    dr_rdy = 0;
    store(9, 32'h0000_0011, 4'b0001);
    dr_rdy = 1;
    store(9, 32'h0000_2200, 4'b0010);
    #1;
    chk("R4 no merge into draining", 64'(dr_v), 1);
    chk("R4 new entry be", 64'(dr_b), 64'(4'b0010));
    step();

    // random traffic on a small address pool
    for (int i = 0; i < 3000; i++) begin
      st_v = 1'($urandom_range(0, 1));
      st_a = AW'($urandom_range(0, 3));
      st_d = $urandom();
      st_b = NB'($urandom());
      dr_rdy = ($urandom_range(0, 2) != 0);
      ld_a = AW'($urandom_range(0, 3));
      ld_b = NB'($urandom());
      cache_d = $urandom();
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule